// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This controller picks which page of special-function registers a small microcontroller core sees on its register bus. The page selector is the top entry of a short hardware stack of bytes. When an interrupt is taken and automatic paging is on, the page that belongs to the interrupting peripheral is pushed, so the handler starts on the right page. A return from interrupt pops the stack, so the interrupted code gets its page back. A direct write to the page register only overwrites the top entry.

A nesting tracker keeps one flag per active interrupt level. Each flag records whether that level's entry actually pushed. A return pops only when its own entry pushed, so handlers entered while paging was off do not disturb the stack. The tracker is a three-state machine. `NEST_BASE` means no interrupt is active. `NEST_ACTIVE` means at least one level is active and there is room for more. `NEST_FULL` means the flag store is full. Its transitions are:

- `T_ENTER_FIRST`: `NEST_BASE` to `NEST_ACTIVE`.
- `T_ENTER_DEEPER`: stays in `NEST_ACTIVE`.
- `T_ENTER_TO_FULL`: `NEST_ACTIVE` to `NEST_FULL`.
- `T_ENTER_AT_FULL`: stays in `NEST_FULL`, and the oldest flag is dropped.
- `T_RETURN_INNER`: stays in `NEST_ACTIVE`.
- `T_RETURN_LAST`: `NEST_ACTIVE` to `NEST_BASE`.
- `T_RETURN_FROM_FULL`: `NEST_FULL` to `NEST_ACTIVE`.
- `T_STRAY_RETURN`: a return in `NEST_BASE`, which is ignored.

Each cycle the stack itself performs one named operation: `OP_HOLD`, `OP_WRITE`, `OP_PUSH`, `OP_WRITE_PUSH` or `OP_POP`.

Top module: `pgstk_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the current page to 0x00 and every stack entry to 0x00. It sets the auto-paging enable to 1 and clears all nesting flags, so a return right after reset does not pop.
- R2: A read of address 0x84 returns the current page, whatever page is selected. Reads of addresses that map to no register return 0x00. Writes to such addresses change nothing.
- R3: The control register sits at address 0x96 and is reachable only while the current page is 0x0F. Bit 0 is the auto-paging enable. Bits 7..1 read as 0, and writes to them are ignored. A write to 0x96 while another page is selected has no effect.
- R4: An interrupt entry (`irq_enter`) with the enable at 1 pushes `irq_page`. That value becomes the current page on the next cycle.
- R5: An interrupt entry with the enable at 0 leaves the current page unchanged and pushes nothing.
- R6: A write to 0x84 replaces the top entry only. It never pushes or pops, so the entries below it are kept.
- R7: A return (`irq_return`) pops only if the matching entry pushed. A return for a level entered with paging off, or a return with no active level, leaves the stack unchanged.
- R8: The stack is 3 entries deep. A push beyond that depth discards the bottom entry. A pop refills the bottom with 0x00.
- R9: A page write and an interrupt entry with paging on in the same cycle store the written value first. The entry then pushes it down, so the written value becomes current again after the matching return.
- R10: An interrupt entry and a return in the same cycle act as the entry alone. The return is ignored.
- R11: A page write and a popping return in the same cycle act as the pop alone. The written value is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write enable |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| irq_enter | input | 1 | One-cycle strobe: an interrupt is taken |
| irq_page | input | 8 | Page tied to the interrupting peripheral, valid with `irq_enter` |
| irq_return | input | 1 | One-cycle strobe: return from interrupt |
| cur_page | output | 8 | Page currently selected (top of stack) |
| autopage_en | output | 1 | Current value of the auto-paging enable |

## Verification
A corrupted stack entry stays hidden until a pop brings it to the top. The bench therefore nests pushes to full depth and unwinds them. Every pop is checked on the cycle after its return strobe, so a lost or shifted entry shows one cycle after the return that exposes it. A wrong nesting flag shows as a page that moves, or fails to move, on the return that follows an entry with paging off. A bad enable bit shows on the first interrupt entry after the control write, and also on a read of 0x96 while page 0x0F is selected.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;

    // Operation applied to the page stack in one cycle
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_WRITE,
        OP_PUSH,
        OP_WRITE_PUSH,
        OP_POP
    } stack_op_e;

    // Interrupt nesting tracker states
    typedef enum logic [1:0] {
        NEST_BASE,
        NEST_ACTIVE,
        NEST_FULL
    } nest_state_e;

endpackage

// File: rtl/pgstk_sfr_port.sv
// Register bus decode, control register and read-data mux.
module pgstk_sfr_port #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  PAGE_ADDR = 8'h84,
    parameter logic [7:0]  CTRL_ADDR = 8'h96,
    parameter logic [7:0]  CTRL_PAGE = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] cur_page,
    output logic              page_wr,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              auto_en
);

    localparam logic [DATA_W-1:0] CTRL_MASK  = DATA_W'(1);
    localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(1);

    logic              hit_page;
    logic              hit_ctrl;
    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_q;

    always_comb begin
        hit_page = (sfr_addr == ADDR_W'(PAGE_ADDR));
        hit_ctrl = (sfr_addr == ADDR_W'(CTRL_ADDR)) &&
                   (cur_page == DATA_W'(CTRL_PAGE));
        page_wr  = sfr_we && hit_page;
        ctrl_wr  = sfr_we && hit_ctrl;
    end

    // Control register: only the enable bit can hold a one
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= sfr_wdata & CTRL_MASK;
        end
    end

    assign auto_en = ctrl_q[0];

    always_comb begin
        if (hit_page) begin
            sfr_rdata = cur_page;
        end else if (hit_ctrl) begin
            sfr_rdata = ctrl_q;
        end else begin
            sfr_rdata = '0;
        end
    end

endmodule

// File: rtl/pgstk_nest_track.sv
// Per-level record of whether an interrupt entry pushed a page.
module pgstk_nest_track
    import pgstk_pkg::*;
#(
    parameter int NEST_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_enter,
    input  logic irq_return,
    input  logic auto_en,
    output logic pop_ok,
    output nest_state_e state
);

    localparam int CNT_W = $clog2(NEST_MAX + 1);
    localparam logic [CNT_W-1:0] LVL_MAX  = CNT_W'(NEST_MAX);
    localparam logic [CNT_W-1:0] LVL_NEAR = CNT_W'(NEST_MAX - 1);
    localparam logic [CNT_W-1:0] LVL_ONE  = CNT_W'(1);

    nest_state_e         state_q, state_d;
    logic [CNT_W-1:0]    depth_q, depth_d;
    logic [NEST_MAX-1:0] flags_q, flags_d;
    logic                do_ret;

    // Entry wins over a return in the same cycle
    assign do_ret = irq_return && !irq_enter;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        depth_d = depth_q;
        flags_d = flags_q;
        unique case (state_q)
            NEST_BASE: begin
                if (irq_enter) begin                 // T_ENTER_FIRST
                    state_d = (LVL_ONE == LVL_MAX) ? NEST_FULL : NEST_ACTIVE;
                    depth_d = LVL_ONE;
                    flags_d = {flags_q[NEST_MAX-2:0], auto_en};
                end
                // T_STRAY_RETURN: nothing changes
            end
            NEST_ACTIVE: begin
                if (irq_enter) begin
                    depth_d = depth_q + LVL_ONE;
                    flags_d = {flags_q[NEST_MAX-2:0], auto_en};
                    if (depth_q == LVL_NEAR) begin   // T_ENTER_TO_FULL
                        state_d = NEST_FULL;
                    end                              // else T_ENTER_DEEPER
                end else if (do_ret) begin
                    depth_d = depth_q - LVL_ONE;
                    flags_d = {1'b0, flags_q[NEST_MAX-1:1]};
                    if (depth_q == LVL_ONE) begin    // T_RETURN_LAST
                        state_d = NEST_BASE;
                    end                              // else T_RETURN_INNER
                end
            end
            NEST_FULL: begin
                if (irq_enter) begin                 // T_ENTER_AT_FULL
                    flags_d = {flags_q[NEST_MAX-2:0], auto_en};
                end else if (do_ret) begin           // T_RETURN_FROM_FULL
                    state_d = NEST_ACTIVE;
                    depth_d = depth_q - LVL_ONE;
                    flags_d = {1'b0, flags_q[NEST_MAX-1:1]};
                end
            end
            default: begin
                state_d = NEST_BASE;
                depth_d = '0;
                flags_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NEST_BASE;
            depth_q <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
            flags_q <= flags_d;
        end
    end

    // Outputs
    always_comb begin
        state  = state_q;
        pop_ok = do_ret && (state_q != NEST_BASE) && flags_q[0];
    end

endmodule

// File: rtl/pgstk_page_stack.sv
// Shift-register page stack; entry 0 is the top.
module pgstk_page_stack
    import pgstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  stack_op_e         op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top
);

    logic [DATA_W-1:0] ent_q   [DEPTH];
    logic [DATA_W-1:0] ent_d   [DEPTH];
    logic [DATA_W-1:0] written [DEPTH];

    // Top entry after an optional direct write
    always_comb begin
        written[0] = ((op == OP_WRITE) || (op == OP_WRITE_PUSH)) ? wr_data : ent_q[0];
    end

    genvar g;
    generate
        for (g = 1; g < DEPTH; g++) begin : g_keep
            assign written[g] = ent_q[g];
        end
    endgenerate

    // Next contents per operation
    generate
        for (g = 0; g < DEPTH; g++) begin : g_next
            logic [DATA_W-1:0] from_above;
            logic [DATA_W-1:0] from_below;
            if (g == 0) begin : g_top
                assign from_above = push_data;
            end else begin : g_mid
                assign from_above = written[g-1];
            end
            if (g == DEPTH - 1) begin : g_bot
                assign from_below = '0;
            end else begin : g_up
                assign from_below = ent_q[g+1];
            end
            always_comb begin
                unique case (op)
                    OP_HOLD:       ent_d[g] = ent_q[g];
                    OP_WRITE:      ent_d[g] = written[g];
                    OP_PUSH,
                    OP_WRITE_PUSH: ent_d[g] = from_above;
                    OP_POP:        ent_d[g] = from_below;
                    default:       ent_d[g] = ent_q[g];
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign top = ent_q[0];

endmodule

// File: rtl/pgstk_ctrl.sv
// Top: register page selector backed by an interrupt-driven stack.
module pgstk_ctrl
    import pgstk_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter int         STACK_DEPTH = 3,
    parameter int         NEST_MAX    = 16,
    parameter logic [7:0] PAGE_ADDR   = 8'h84,
    parameter logic [7:0] CTRL_ADDR   = 8'h96,
    parameter logic [7:0] CTRL_PAGE   = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              irq_enter,
    input  logic [DATA_W-1:0] irq_page,
    input  logic              irq_return,
    output logic [DATA_W-1:0] cur_page,
    output logic              autopage_en
);

    logic        page_wr;
    logic        auto_en;
    logic        pop_ok;
    logic        do_push;
    stack_op_e   op;
    nest_state_e nest_state;
    logic [DATA_W-1:0] top;

    pgstk_sfr_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PAGE_ADDR(PAGE_ADDR),
        .CTRL_ADDR(CTRL_ADDR),
        .CTRL_PAGE(CTRL_PAGE)
    ) u_port (
        .clk      (clk),
        .rst      (rst),
        .sfr_addr (sfr_addr),
        .sfr_wdata(sfr_wdata),
        .sfr_we   (sfr_we),
        .cur_page (top),
        .page_wr  (page_wr),
        .sfr_rdata(sfr_rdata),
        .auto_en  (auto_en)
    );

    pgstk_nest_track #(
        .NEST_MAX(NEST_MAX)
    ) u_nest (
        .clk       (clk),
        .rst       (rst),
        .irq_enter (irq_enter),
        .irq_return(irq_return),
        .auto_en   (auto_en),
        .pop_ok    (pop_ok),
        .state     (nest_state)
    );

    // Operation select: push beats pop; a popped write is lost
    assign do_push = irq_enter && auto_en;

    always_comb begin
        if (do_push && page_wr) begin
            op = OP_WRITE_PUSH;
        end else if (do_push) begin
            op = OP_PUSH;
        end else if (pop_ok) begin
            op = OP_POP;
        end else if (page_wr) begin
            op = OP_WRITE;
        end else begin
            op = OP_HOLD;
        end
    end

    pgstk_page_stack #(
        .DATA_W(DATA_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_data  (sfr_wdata),
        .push_data(irq_page),
        .top      (top)
    );

    assign cur_page    = top;
    assign autopage_en = auto_en;

    logic unused_state;
    assign unused_state = ^nest_state;

endmodule

// File: rtl/pgstk_ctrl_chk.sv
// Port-level properties of pgstk_ctrl.
module pgstk_ctrl_chk #(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] PAGE_ADDR = 8'h84,
    parameter logic [7:0] CTRL_ADDR = 8'h96,
    parameter logic [7:0] CTRL_PAGE = 8'h0F
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic              irq_enter,
    input logic [DATA_W-1:0] irq_page,
    input logic              irq_return,
    input logic [DATA_W-1:0] cur_page,
    input logic              autopage_en
);

    logic wr_page;
    logic on_ctrl;
    assign wr_page = sfr_we && (sfr_addr == ADDR_W'(PAGE_ADDR));
    assign on_ctrl = (sfr_addr == ADDR_W'(CTRL_ADDR)) && (cur_page == DATA_W'(CTRL_PAGE));

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cur_page == '0) && autopage_en);

    // R2
    a_r2_page_readback: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == ADDR_W'(PAGE_ADDR)) |-> (sfr_rdata == cur_page));

    // R3
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        on_ctrl |-> (sfr_rdata[DATA_W-1:1] == '0));

    // R3
    a_r3_ctrl_page_gate: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && (sfr_addr == ADDR_W'(CTRL_ADDR)) && (cur_page != DATA_W'(CTRL_PAGE)))
        |=> $stable(autopage_en));

    // R4
    a_r4_push_page: assert property (@(posedge clk) disable iff (rst)
        (irq_enter && autopage_en) |=> (cur_page == $past(irq_page)));

    // R5
    a_r5_no_push_off: assert property (@(posedge clk) disable iff (rst)
        (irq_enter && !autopage_en && !wr_page) |=> $stable(cur_page));

    // R6
    a_r6_write_top: assert property (@(posedge clk) disable iff (rst)
        (wr_page && !irq_enter && !irq_return) |=> (cur_page == $past(sfr_wdata)));

endmodule

bind pgstk_ctrl pgstk_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_ADDR(PAGE_ADDR),
    .CTRL_ADDR(CTRL_ADDR),
    .CTRL_PAGE(CTRL_PAGE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sfr_addr   (sfr_addr),
    .sfr_wdata  (sfr_wdata),
    .sfr_we     (sfr_we),
    .sfr_rdata  (sfr_rdata),
    .irq_enter  (irq_enter),
    .irq_page   (irq_page),
    .irq_return (irq_return),
    .cur_page   (cur_page),
    .autopage_en(autopage_en)
);

// File: tb/pgstk_ctrl_bench.sv
module pgstk_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_rdata;
    logic       irq_enter = 1'b0;
    logic [7:0] irq_page = '0;
    logic       irq_return = 1'b0;
    logic [7:0] cur_page;
    logic       autopage_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgstk_ctrl u_pgstk_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sfr_addr   (sfr_addr),
        .sfr_wdata  (sfr_wdata),
        .sfr_we     (sfr_we),
        .sfr_rdata  (sfr_rdata),
        .irq_enter  (irq_enter),
        .irq_page   (irq_page),
        .irq_return (irq_return),
        .cur_page   (cur_page),
        .autopage_en(autopage_en)
    );

    typedef struct packed {
        logic       ent;
        logic       ret;
        logic       we;
        logic [7:0] addr;
        logic [7:0] wd;
        logic [7:0] ip;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 8'h84, 8'h11, 8'h00, 8'h11, 8'd6},  // R6 write top
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h22, 8'h22, 8'd4},  // R4 push
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h33, 8'h33, 8'd4},  // R4 push
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h44, 8'h44, 8'd8},  // R8 overflow drops 0x11
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h33, 8'd7},  // R7 pop
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h22, 8'd7},  // R7 pop
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'd8},  // R8 zero refill
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'd7},  // R7 stray return
        '{1'b0, 1'b0, 1'b1, 8'h84, 8'h0F, 8'h00, 8'h0F, 8'd6},  // R6
        '{1'b0, 1'b0, 1'b1, 8'h96, 8'hFE, 8'h00, 8'h0F, 8'd3},  // R3 disable
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h55, 8'h0F, 8'd5},  // R5 no push
        '{1'b0, 1'b0, 1'b1, 8'h84, 8'h66, 8'h00, 8'h66, 8'd6},  // R6
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h66, 8'd7},  // R7 unflagged return
        '{1'b0, 1'b0, 1'b1, 8'h84, 8'h0F, 8'h00, 8'h0F, 8'd6},  // R6
        '{1'b0, 1'b0, 1'b1, 8'h96, 8'h01, 8'h00, 8'h0F, 8'd3},  // R3 enable
        '{1'b1, 1'b0, 1'b1, 8'h84, 8'h21, 8'h77, 8'h77, 8'd9},  // R9 write+push
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h21, 8'd9},  // R9 written value back
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h31, 8'h31, 8'd10}, // R10 entry wins
        '{1'b0, 1'b1, 1'b1, 8'h84, 8'h99, 8'h00, 8'h21, 8'd11}, // R11 pop wins
        '{1'b0, 1'b0, 1'b1, 8'h96, 8'h00, 8'h00, 8'h21, 8'd3},  // R3 off-page write
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h42, 8'h42, 8'd3},  // R3 enable still 1
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h21, 8'd7},  // R7
        '{1'b0, 1'b0, 1'b1, 8'h85, 8'h55, 8'h00, 8'h21, 8'd2}   // R2 unmapped write
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus just after a falling edge; result visible at next falling edge
    task automatic cycle(input logic ent, input logic ret, input logic we,
                         input logic [7:0] addr, input logic [7:0] wd, input logic [7:0] ip);
        irq_enter  = ent;
        irq_return = ret;
        sfr_we     = we;
        sfr_addr   = addr;
        sfr_wdata  = wd;
        irq_page   = ip;
        @(negedge clk);
        irq_enter  = 1'b0;
        irq_return = 1'b0;
        sfr_we     = 1'b0;
        sfr_addr   = '0;
    endtask

    task automatic read_at(input logic [7:0] addr, output logic [7:0] val);
        sfr_addr = addr;
        #1;
        val = sfr_rdata;
        sfr_addr = '0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check8("R1 page after reset", cur_page, 8'h00);
        check8("R1 enable after reset", {7'd0, autopage_en}, 8'h01);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i].ent, VEC[i].ret, VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].ip);
            checks++;
            if (cur_page !== VEC[i].exp) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual=%02h expected=%02h",
                         VEC[i].req, i, cur_page, VEC[i].exp);
            end
        end

        // R2 readback of the page register from an arbitrary page
        read_at(8'h84, rd);
        check8("R2 read 0x84", rd, 8'h21);
        read_at(8'h50, rd);
        check8("R2 unmapped read", rd, 8'h00);
        read_at(8'h96, rd);
        check8("R3 ctrl hidden off page 0x0F", rd, 8'h00);

        // R3 control register on page 0x0F, reserved bits
        cycle(1'b0, 1'b0, 1'b1, 8'h84, 8'h0F, 8'h00);
        read_at(8'h96, rd);
        check8("R3 ctrl read", rd, 8'h01);
        cycle(1'b0, 1'b0, 1'b1, 8'h96, 8'hFF, 8'h00);
        read_at(8'h96, rd);
        check8("R3 reserved bits ignored", rd, 8'h01);
        cycle(1'b0, 1'b0, 1'b1, 8'h96, 8'hFE, 8'h00);
        read_at(8'h96, rd);
        check8("R3 reserved read zero after disable", rd, 8'h00);

        // R5 disabled entry, then R7 its return leaves stack alone
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA5);
        check8("R5 page unchanged", cur_page, 8'h0F);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
        check8("R7 return of unpushed level", cur_page, 8'h0F);
        cycle(1'b0, 1'b0, 1'b1, 8'h96, 8'h01, 8'h00);

        // R1 mid-run reset after nesting
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3C);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h0F);
        cycle(1'b0, 1'b0, 1'b1, 8'h96, 8'h00, 8'h00);
        check8("R3 enable cleared on page 0x0F", {7'd0, autopage_en}, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check8("R1 page after mid reset", cur_page, 8'h00);
        check8("R1 enable after mid reset", {7'd0, autopage_en}, 8'h01);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
        check8("R1 nesting cleared, return no pop", cur_page, 8'h00);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h5A);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
        check8("R8 pop after reset refills zero", cur_page, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule